// File: doc/BRIEF.md
# Palette Host Access Controller

This block connects an 8-bit host bus to a 256-entry colour lookup table whose entries are 18 bits wide, made of three 6-bit colour fields. The host selects one of four targets with a 2-bit select code. The targets are an entry address loaded for writing, the same address loaded for reading, a colour data port and an 8-bit pixel mask. A hidden three-step colour phase sits under the 8-bit entry address. Palette data accesses step through red, green and blue. After the blue step the entry is written, or the next entry is fetched, and the address moves on.

The read and write strobes are active low and asynchronous to the system clock. Each strobe passes through a synchronizer, and the block acts only when it sees the strobe deasserted. Select and write data are sampled at that moment. The host must therefore hold them stable for at least SYNC_STAGES+1 clocks after it releases the strobe. Read data is driven from registered state through a multiplexer chosen by the live select code, so it is valid while the read strobe is held low.

Storage is reached through two valid/ready request channels and one response input. A request stays asserted, with address and data stable, until the storage accepts it with ready. The storage returns exactly one response pulse for each accepted read request, after any latency, and the controller always takes it. A channel carries one outstanding request at a time, so the host must space its accesses so that each request is accepted before the next access that would issue one.

Top module: `pal_host_ctrl`

## Requirements
- R1: Select codes: 00 is the address in write mode, 11 is the address in read mode, 01 is colour data, and 10 is the pixel mask. Reading either address code returns the 8-bit entry address and changes neither the address nor the colour phase.
- R2: A write with code 00 or 11 loads bus bits 7:0 into the entry address and resets the colour phase to red, so a partly entered colour is dropped.
- R3: Colour data occupies bus bits 5:0 (bit 0 is LSB). Bits 7:6 are ignored on writes and read back as zero.
- R4: The third (blue) colour data write issues exactly one storage write of {red, green, blue} to the current entry address, with red in bits 17:12, green in 11:6 and blue in 5:0.
- R5: The entry address increments after each blue colour read or write, and wraps from FFh to 00h.
- R6: A write with code 11 fetches the addressed entry. Colour data reads then return its red, green and blue fields in that order. After the blue read the next entry is fetched.
- R7: An access during which both strobes were asserted together has no effect on any state.
- R8: The pixel mask resets to FFh. It is written and read as a full 8-bit value through code 10, appears on `pix_mask`, and changes only on such a write.
- R9: A storage request that is not accepted stays valid with unchanged address and data until ready is seen high.
- R10: After reset the entry address is 00h, the phase is red and the mask is FFh.
- R11: A write takes effect on the third rising clock edge after the write strobe is released (two synchronizer edges and one register edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 2 | Target select code |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected target |
| host_wr_n | input | 1 | Write strobe, active low |
| host_rd_n | input | 1 | Read strobe, active low |
| pix_mask | output | 8 | Current pixel mask value |
| lut_wr_valid | output | 1 | Storage write request valid |
| lut_wr_ready | input | 1 | Storage accepts the write request |
| lut_wr_addr | output | 8 | Storage write entry address |
| lut_wr_data | output | 18 | Storage write entry {red, green, blue} |
| lut_rd_valid | output | 1 | Storage read request valid |
| lut_rd_ready | input | 1 | Storage accepts the read request |
| lut_rd_addr | output | 8 | Storage read entry address |
| lut_rsp_valid | input | 1 | One-cycle pulse carrying read response data |
| lut_rsp_data | input | 18 | Read response entry {red, green, blue} |

## Verification
Back-to-back red/green/blue write runs over neighbouring entries show whether the phase counter and the increment stay in step. Aborted sequences, which reload the address after one byte, show whether the phase really resets. Runs that end at entry FFh, in both write and read mode, catch a missing or misplaced wrap. Read-mode runs against a bench reference array confirm that all three bytes come from the same entry. Overlapped strobes, mask writes timed edge by edge, and a storage model that withholds ready in a fixed pattern separate lost or doubled requests from correct back-pressure handling.

// File: rtl/pal_host_pkg.sv
package pal_host_pkg;
  localparam int DEF_COLOR_W = 6;
  localparam int DEF_ADDR_W  = 8;

  typedef enum logic [1:0] {
    SEL_ADDR_WR = 2'b00,
    SEL_DATA    = 2'b01,
    SEL_MASK    = 2'b10,
    SEL_ADDR_RD = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_strobe_sync.sv
module pal_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic active,
  output logic release_pulse
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      last_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], strobe_n};
      last_q  <= chain_q[STAGES-1];
    end
  end

  // strobe seen low after synchronization
  assign active        = ~chain_q[STAGES-1];
  // strobe just went back high
  assign release_pulse = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/pal_bus_guard.sv
module pal_bus_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_active,
  input  logic rd_active,
  input  logic wr_release,
  input  logic rd_release,
  output logic wr_evt,
  output logic rd_evt,
  output logic both_low
);
  logic overlap_q;

  assign both_low = wr_active & rd_active;

  // Sticky from the first cycle both strobes are low until both are high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overlap_q <= 1'b0;
    end else if (both_low) begin
      overlap_q <= 1'b1;
    end else if (!wr_active && !rd_active) begin
      overlap_q <= 1'b0;
    end
  end

  assign wr_evt = wr_release & ~overlap_q;
  assign rd_evt = rd_release & ~overlap_q;
endmodule

// File: rtl/pal_req_hold.sv
module pal_req_hold #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [PW-1:0] go_payload,
  output logic          valid,
  input  logic          ready,
  output logic [PW-1:0] payload
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid   <= 1'b0;
      payload <= '0;
    end else if (go) begin
      valid   <= 1'b1;
      payload <= go_payload;
    end else if (valid && ready) begin
      valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/pal_access_core.sv
module pal_access_core
  import pal_host_pkg::*;
#(
  parameter int              COLOR_W    = DEF_COLOR_W,
  parameter int              ADDR_W     = DEF_ADDR_W,
  parameter logic [ADDR_W-1:0] MASK_RESET = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_evt,
  input  logic                   rd_evt,
  input  logic [1:0]             sel,
  input  logic [ADDR_W-1:0]      wdata,
  input  logic                   rsp_valid,
  input  logic [3*COLOR_W-1:0]   rsp_data,
  output logic [ADDR_W-1:0]      rdata,
  output logic [ADDR_W-1:0]      mask,
  output logic [ADDR_W-1:0]      entry_addr,
  output phase_e                 phase,
  output logic                   wr_go,
  output logic [ADDR_W-1:0]      wr_addr,
  output logic [3*COLOR_W-1:0]   wr_entry,
  output logic                   rd_go,
  output logic [ADDR_W-1:0]      rd_addr
);
  localparam int              ENTRY_W = 3 * COLOR_W;
  localparam int              PAD_W   = ADDR_W - COLOR_W;
  localparam logic [ADDR_W-1:0] ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};

  sel_e                sel_c;
  phase_e              phase_q, phase_nx;
  logic [ADDR_W-1:0]   addr_q, mask_q, addr_inc;
  logic [COLOR_W-1:0]  col_q [3];
  logic [COLOR_W-1:0]  byte_in, cur_byte;
  logic                wr_go_q, rd_go_q;
  logic [ADDR_W-1:0]   wr_addr_q, rd_addr_q;
  logic [ENTRY_W-1:0]  wr_entry_q;

  assign sel_c    = sel_e'(sel);
  assign byte_in  = wdata[COLOR_W-1:0];
  assign addr_inc = addr_q + ONE;

  always_comb begin
    case (phase_q)
      PH_RED:   begin phase_nx = PH_GREEN; cur_byte = col_q[0]; end
      PH_GREEN: begin phase_nx = PH_BLUE;  cur_byte = col_q[1]; end
      default:  begin phase_nx = PH_RED;   cur_byte = col_q[2]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      mask_q     <= MASK_RESET;
      phase_q    <= PH_RED;
      for (int i = 0; i < 3; i++) col_q[i] <= '0;
      wr_go_q    <= 1'b0;
      rd_go_q    <= 1'b0;
      wr_addr_q  <= '0;
      rd_addr_q  <= '0;
      wr_entry_q <= '0;
    end else begin
      wr_go_q <= 1'b0;
      rd_go_q <= 1'b0;
      if (rsp_valid) begin
        col_q[0] <= rsp_data[ENTRY_W-1 -: COLOR_W];
        col_q[1] <= rsp_data[2*COLOR_W-1 -: COLOR_W];
        col_q[2] <= rsp_data[COLOR_W-1:0];
      end
      if (wr_evt) begin
        case (sel_c)
          SEL_ADDR_WR: begin
            addr_q  <= wdata;
            phase_q <= PH_RED;
          end
          SEL_ADDR_RD: begin
            addr_q    <= wdata;
            phase_q   <= PH_RED;
            rd_go_q   <= 1'b1;
            rd_addr_q <= wdata;
          end
          SEL_DATA: begin
            for (int i = 0; i < 3; i++) begin
              if (phase_q == phase_e'(i)) col_q[i] <= byte_in;
            end
            if (phase_q == PH_BLUE) begin
              wr_go_q    <= 1'b1;
              wr_addr_q  <= addr_q;
              wr_entry_q <= {col_q[0], col_q[1], byte_in};
              addr_q     <= addr_inc;
            end
            phase_q <= phase_nx;
          end
          default: mask_q <= wdata;
        endcase
      end else if (rd_evt && sel_c == SEL_DATA) begin
        if (phase_q == PH_BLUE) begin
          addr_q    <= addr_inc;
          rd_go_q   <= 1'b1;
          rd_addr_q <= addr_inc;
        end
        phase_q <= phase_nx;
      end
    end
  end

  always_comb begin
    case (sel_c)
      SEL_DATA: rdata = {{PAD_W{1'b0}}, cur_byte};
      SEL_MASK: rdata = mask_q;
      default:  rdata = addr_q;
    endcase
  end

  assign mask       = mask_q;
  assign entry_addr = addr_q;
  assign phase      = phase_q;
  assign wr_go      = wr_go_q;
  assign wr_addr    = wr_addr_q;
  assign wr_entry   = wr_entry_q;
  assign rd_go      = rd_go_q;
  assign rd_addr    = rd_addr_q;
endmodule

// File: rtl/pal_host_ctrl.sv
module pal_host_ctrl
  import pal_host_pkg::*;
#(
  parameter int                COLOR_W     = DEF_COLOR_W,
  parameter int                ADDR_W      = DEF_ADDR_W,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] MASK_RESET  = '1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           host_sel,
  input  logic [ADDR_W-1:0]    host_wdata,
  output logic [ADDR_W-1:0]    host_rdata,
  input  logic                 host_wr_n,
  input  logic                 host_rd_n,
  output logic [ADDR_W-1:0]    pix_mask,
  output logic                 lut_wr_valid,
  input  logic                 lut_wr_ready,
  output logic [ADDR_W-1:0]    lut_wr_addr,
  output logic [3*COLOR_W-1:0] lut_wr_data,
  output logic                 lut_rd_valid,
  input  logic                 lut_rd_ready,
  output logic [ADDR_W-1:0]    lut_rd_addr,
  input  logic                 lut_rsp_valid,
  input  logic [3*COLOR_W-1:0] lut_rsp_data
);
  localparam int ENTRY_W     = 3 * COLOR_W;
  localparam int NUM_STROBES = 2;
  localparam int WR_PW       = ADDR_W + ENTRY_W;

  logic [NUM_STROBES-1:0] strobe_n_vec, active_vec, release_vec;
  logic                   wr_evt, rd_evt, both_low;
  logic                   wr_go, rd_go;
  logic [ADDR_W-1:0]      wr_addr, rd_addr, entry_addr;
  logic [ENTRY_W-1:0]     wr_entry;
  phase_e                 phase;

  // index 0: write strobe, index 1: read strobe
  assign strobe_n_vec = {host_rd_n, host_wr_n};

  for (genvar s = 0; s < NUM_STROBES; s++) begin : g_sync
    pal_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk          (clk),
      .rst_n        (rst_n),
      .strobe_n     (strobe_n_vec[s]),
      .active       (active_vec[s]),
      .release_pulse(release_vec[s])
    );
  end

  pal_bus_guard u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_active (active_vec[0]),
    .rd_active (active_vec[1]),
    .wr_release(release_vec[0]),
    .rd_release(release_vec[1]),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .both_low  (both_low)
  );

  pal_access_core #(
    .COLOR_W   (COLOR_W),
    .ADDR_W    (ADDR_W),
    .MASK_RESET(MASK_RESET)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_evt    (wr_evt),
    .rd_evt    (rd_evt),
    .sel       (host_sel),
    .wdata     (host_wdata),
    .rsp_valid (lut_rsp_valid),
    .rsp_data  (lut_rsp_data),
    .rdata     (host_rdata),
    .mask      (pix_mask),
    .entry_addr(entry_addr),
    .phase     (phase),
    .wr_go     (wr_go),
    .wr_addr   (wr_addr),
    .wr_entry  (wr_entry),
    .rd_go     (rd_go),
    .rd_addr   (rd_addr)
  );

  pal_req_hold #(.PW(WR_PW)) u_wr_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (wr_go),
    .go_payload({wr_addr, wr_entry}),
    .valid     (lut_wr_valid),
    .ready     (lut_wr_ready),
    .payload   ({lut_wr_addr, lut_wr_data})
  );

  pal_req_hold #(.PW(ADDR_W)) u_rd_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (rd_go),
    .go_payload(rd_addr),
    .valid     (lut_rd_valid),
    .ready     (lut_rd_ready),
    .payload   (lut_rd_addr)
  );
endmodule

// File: rtl/pal_host_ctrl_chk.sv
module pal_host_ctrl_chk #(
  parameter int COLOR_W = 6,
  parameter int ADDR_W  = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_evt,
  input logic                 rd_evt,
  input logic                 both_low,
  input logic                 wr_go,
  input logic [1:0]           host_sel,
  input logic [ADDR_W-1:0]    host_wdata,
  input logic [ADDR_W-1:0]    entry_addr,
  input logic [1:0]           phase,
  input logic [ADDR_W-1:0]    pix_mask,
  input logic                 lut_wr_valid,
  input logic                 lut_wr_ready,
  input logic [ADDR_W-1:0]    lut_wr_addr,
  input logic [3*COLOR_W-1:0] lut_wr_data,
  input logic                 lut_rd_valid,
  input logic                 lut_rd_ready,
  input logic [ADDR_W-1:0]    lut_rd_addr
);
  // R2
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && (host_sel == 2'b00 || host_sel == 2'b11)) |=> entry_addr == $past(host_wdata));

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && host_sel == 2'b01 && phase == 2'd2) |=> entry_addr == ADDR_W'($past(entry_addr) + 1));

  // R7
  overlap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(both_low) |-> (!wr_evt && !rd_evt));

  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && host_sel == 2'b10) |=> $stable(pix_mask));

  // R4
  wr_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> lut_wr_valid);

  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_wr_valid && !lut_wr_ready) |=> (lut_wr_valid && $stable(lut_wr_addr) && $stable(lut_wr_data)));

  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lut_rd_valid && !lut_rd_ready) |=> (lut_rd_valid && $stable(lut_rd_addr)));
endmodule

bind pal_host_ctrl pal_host_ctrl_chk #(.COLOR_W(COLOR_W), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_evt      (wr_evt),
  .rd_evt      (rd_evt),
  .both_low    (both_low),
  .wr_go       (wr_go),
  .host_sel    (host_sel),
  .host_wdata  (host_wdata),
  .entry_addr  (entry_addr),
  .phase       (phase),
  .pix_mask    (pix_mask),
  .lut_wr_valid(lut_wr_valid),
  .lut_wr_ready(lut_wr_ready),
  .lut_wr_addr (lut_wr_addr),
  .lut_wr_data (lut_wr_data),
  .lut_rd_valid(lut_rd_valid),
  .lut_rd_ready(lut_rd_ready),
  .lut_rd_addr (lut_rd_addr)
);

// File: tb/pal_host_ctrl_bench.sv
`timescale 1ns/1ps
module pal_host_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = 2'b00;
  logic [7:0]  host_wdata = 8'h00;
  logic [7:0]  host_rdata;
  logic        host_wr_n = 1'b1;
  logic        host_rd_n = 1'b1;
  logic [7:0]  pix_mask;
  logic        lut_wr_valid, lut_rd_valid;
  logic        lut_wr_ready, lut_rd_ready;
  logic [7:0]  lut_wr_addr, lut_rd_addr;
  logic [17:0] lut_wr_data;
  logic        lut_rsp_valid;
  logic [17:0] lut_rsp_data;

  always #2 clk = ~clk;

  pal_host_ctrl u_pal_host_ctrl (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_wr_n(host_wr_n), .host_rd_n(host_rd_n),
    .pix_mask(pix_mask), .lut_wr_valid(lut_wr_valid), .lut_wr_ready(lut_wr_ready),
    .lut_wr_addr(lut_wr_addr), .lut_wr_data(lut_wr_data), .lut_rd_valid(lut_rd_valid),
    .lut_rd_ready(lut_rd_ready), .lut_rd_addr(lut_rd_addr),
    .lut_rsp_valid(lut_rsp_valid), .lut_rsp_data(lut_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] seed(input int i);
    return 18'((i * 37 + 5) ^ (i << 10));
  endfunction

  // ---------------- storage model with ready stalls ----------------
  int          cyc = 0;
  int          wr_hs = 0;
  logic [17:0] mem [256];
  assign lut_wr_ready = (cyc % 3) != 1;
  assign lut_rd_ready = (cyc % 4) != 2;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
      lut_rsp_valid <= 1'b0;
      lut_rsp_data  <= '0;
    end else begin
      if (lut_wr_valid && lut_wr_ready) begin
        mem[lut_wr_addr] <= lut_wr_data;
        wr_hs <= wr_hs + 1;
      end
      lut_rsp_valid <= lut_rd_valid && lut_rd_ready;
      lut_rsp_data  <= mem[lut_rd_addr];
    end
  end

  // R9: per-clock back-pressure check on the write channel
  bit          prev_stall = 0;
  logic [7:0]  prev_addr;
  logic [17:0] prev_data;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(lut_wr_valid && lut_wr_addr == prev_addr && lut_wr_data == prev_data,
            "R9 wr hold", int'(lut_wr_data), int'(prev_data));
      end
      prev_stall = lut_wr_valid && !lut_wr_ready;
      prev_addr  = lut_wr_addr;
      prev_data  = lut_wr_data;
    end
  end

  // ---------------- behavioural reference model ----------------
  int          m_addr = 0, m_phase = 0, m_mask = 255, exp_writes = 0;
  int          m_col [3];
  logic [17:0] ref_mem [256];

  function automatic void load_cols(input int a);
    m_col[0] = int'(ref_mem[a][17:12]);
    m_col[1] = int'(ref_mem[a][11:6]);
    m_col[2] = int'(ref_mem[a][5:0]);
  endfunction

  function automatic void model_wr(input int sel, input int d);
    case (sel)
      0: begin m_addr = d; m_phase = 0; end
      3: begin m_addr = d; m_phase = 0; load_cols(d); end
      2: m_mask = d;
      default: begin
        m_col[m_phase] = d & 63;
        if (m_phase == 2) begin
          ref_mem[m_addr] = {m_col[0][5:0], m_col[1][5:0], m_col[2][5:0]};
          exp_writes++;
          m_addr = (m_addr + 1) % 256;
          m_phase = 0;
        end else m_phase++;
      end
    endcase
  endfunction

  function automatic int model_rd(input int sel);
    int e;
    case (sel)
      2: e = m_mask;
      1: begin
        e = m_col[m_phase];
        if (m_phase == 2) begin
          m_addr = (m_addr + 1) % 256;
          m_phase = 0;
          load_cols(m_addr);
        end else m_phase++;
      end
      default: e = m_addr;
    endcase
    return e;
  endfunction

  // ---------------- host bus tasks ----------------
  task automatic bus_wr(input int sel, input int d);
    @(negedge clk);
    host_sel = 2'(sel); host_wdata = 8'(d); host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (10) @(negedge clk);
    model_wr(sel, d);
  endtask

  task automatic bus_rd(input int sel, input string req);
    int e;
    int got;
    @(negedge clk);
    host_sel = 2'(sel); host_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    got = int'(host_rdata);
    host_rd_n = 1'b1;
    repeat (12) @(negedge clk);
    e = model_rd(sel);
    chk(got == e, req, got, e);
  endtask

  task automatic bus_overlap(input int sel, input int d);
    @(negedge clk);
    host_sel = 2'(sel); host_wdata = 8'(d);
    host_rd_n = 1'b0; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    host_rd_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic chk_mem(input int a, input string req);
    chk(mem[a] == ref_mem[a], req, int'(mem[a]), int'(ref_mem[a]));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = seed(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R10 reset state
    host_sel = 2'b00; #1;
    chk(host_rdata == 8'h00, "R10 reset addr", int'(host_rdata), 0);
    chk(pix_mask == 8'hFF, "R10 reset mask", int'(pix_mask), 255);
    bus_rd(2, "R8 reset mask readback");

    // R1/R2 address load and non-destructive readback
    bus_wr(0, 8'h10);
    bus_rd(0, "R1 addr read");
    bus_rd(3, "R1 addr read code 11");

    // R3/R4/R5 back-to-back writes with junk in bits 7:6
    for (int e = 0; e < 3; e++) begin
      bus_wr(1, 8'hC0 | (e * 5 + 1));
      bus_wr(1, 8'h80 | (e * 7 + 2));
      bus_wr(1, 8'h40 | (e * 11 + 3));
    end
    chk_mem(8'h10, "R4 entry 10");
    chk_mem(8'h11, "R4 entry 11");
    chk_mem(8'h12, "R3 entry 12");
    bus_rd(0, "R5 addr after three entries");

    // R2 aborted sequence: reload clears phase
    bus_wr(0, 8'h20);
    bus_wr(1, 8'h3F);
    bus_wr(0, 8'h21);
    bus_wr(1, 8'h01); bus_wr(1, 8'h02); bus_wr(1, 8'h03);
    chk_mem(8'h20, "R2 entry 20 untouched");
    chk_mem(8'h21, "R2 entry 21 fresh phase");

    // R5 write wrap at FF
    bus_wr(0, 8'hFF);
    bus_wr(1, 8'h15); bus_wr(1, 8'h2A); bus_wr(1, 8'h33);
    chk_mem(8'hFF, "R4 entry FF");
    bus_rd(0, "R5 write wrap to 00");

    // R6 read-mode prefetch over written entries
    bus_wr(3, 8'h10);
    for (int e = 0; e < 3; e++) begin
      bus_rd(1, "R6 red");
      bus_rd(1, "R6 green");
      bus_rd(1, "R3 blue upper bits zero");
    end
    bus_rd(0, "R5 addr after reads");

    // R5/R6 read wrap
    bus_wr(3, 8'hFE);
    for (int k = 0; k < 6; k++) bus_rd(1, "R6 read near wrap");
    bus_rd(0, "R5 read wrap to 00");
    bus_rd(1, "R6 red of entry 00");

    // R8 mask and R1 no address change
    bus_wr(2, 8'h5A);
    chk(pix_mask == 8'h5A, "R8 mask output", int'(pix_mask), 8'h5A);
    bus_rd(2, "R8 mask readback");
    bus_rd(0, "R1 mask leaves addr");

    // R7 overlapped strobes ignored
    bus_wr(3, 8'h30);
    bus_rd(1, "R6 red of 30");
    bus_overlap(1, 8'h3F);
    bus_overlap(2, 8'h11);
    chk(pix_mask == 8'h5A, "R7 mask unchanged", int'(pix_mask), 8'h5A);
    bus_rd(1, "R7 green after overlap");
    bus_rd(0, "R7 addr unchanged");
    bus_overlap(0, 8'h77);
    bus_rd(0, "R7 addr load ignored");

    // R11 write latency: effect on third edge after release
    @(negedge clk);
    host_sel = 2'b10; host_wdata = 8'hC3; host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pix_mask == 8'h5A, "R11 not yet", int'(pix_mask), 8'h5A);
    @(negedge clk);
    chk(pix_mask == 8'hC3, "R11 third edge", int'(pix_mask), 8'hC3);
    repeat (8) @(negedge clk);
    model_wr(2, 8'hC3);

    // R4/R9 exactly one storage write per blue byte
    chk(wr_hs == exp_writes, "R9 write count", wr_hs, exp_writes);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule